// File: doc/BRIEF.md
# Dual-Role Serial Sample Output Port

This block takes completed I/Q sample pairs from two receive channels (A and B) and shifts them out on two serial data lines that share one serial clock, one frame sync and one data-ready flag. A single configuration word sets the behaviour of both lines together. It selects the bus role, the word length (16 or 24 bits), whether channel B has its own line or follows channel A on the first line, and the serial clock divider.

As a bus master the port makes the serial clock from the system clock and issues the frame sync itself. As a slave it takes both from an external DSP. The DSP watches the ready flag and then raises frame sync one serial clock before it wants the data. Because a master's frame sync can drive a slave's frame-sync input, ports on separate devices can be chained so that they shift their frames together on the common clock.

The slave clock and frame sync are resynchronised into the system clock domain. For this reason each phase of the external serial clock must last at least four system clock cycles.

Top module: `serout_port`

## Requirements
- R1: After reset the configuration is slave role, 16-bit words, separate lines and divide word 0. `sdo0`, `sdo1`, `sclk_out`, `fs_out` and `ready` are all low.
- R2: A cycle with `cfg_we` high loads `cfg_wdata` into the configuration word. Bit 0 selects the master role, bit 1 selects 24-bit words, bit 2 sends both channels on `sdo0`, and bits [DIV_W+2:3] hold the divide word D.
- R3: In master role `sclk_out` has a period of 2×(D+1) system clocks and is high for half of it. In slave role `sclk_out` and `fs_out` stay low.
- R4: A `load` pulse captures the four 24-bit sample words and raises `ready`. A further `load` before the frame starts replaces the buffered words.
- R5: In master role, once `ready` is high, `fs_out` rises at the next falling `sclk_out` edge and stays high for exactly one serial period. The first data bit appears at the rising edge that follows the frame-sync period. Without buffered data `fs_out` stays low.
- R6: In slave role `fs_in` is sampled at each rising `sclk_in` edge. If it is high while `ready` is high, the first data bit is driven at the next rising edge.
- R7: Data goes out most significant bit first, changing on rising serial clock edges. With 24-bit words each word is sent whole. With 16-bit words bits [23:8] of each word are sent.
- R8: With separate lines, `sdo0` carries A I then A Q, and `sdo1` carries B I then B Q on the same edges.
- R9: With the single-line setting, `sdo0` carries A I, A Q, B I, B Q in that order, and `sdo1` stays low.
- R10: `ready` falls at the rising edge that drives the first bit of the frame.
- R11: At the rising edge after the last bit, both data lines return low and the port goes idle.
- R12: In slave role, a frame sync that arrives while `ready` is low is ignored and both data lines stay low.
- R13: When a master's `sclk_out` and `fs_out` drive a slave's `sclk_in` and `fs_in`, the slave's frame comes out bit-for-bit in the same serial periods as the master's.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | DIV_W+3 | Configuration word: role, width, routing, divide |
| load | input | 1 | Sample pair strobe for both channels |
| a_i | input | WIDE_W | Channel A in-phase word |
| a_q | input | WIDE_W | Channel A quadrature word |
| b_i | input | WIDE_W | Channel B in-phase word |
| b_q | input | WIDE_W | Channel B quadrature word |
| sclk_in | input | 1 | Serial clock from an external controller (slave role) |
| fs_in | input | 1 | Frame sync from an external controller or master port |
| sclk_out | output | 1 | Generated serial clock (master role) |
| fs_out | output | 1 | Generated frame sync (master role) |
| sdo0 | output | 1 | Serial data line 0 |
| sdo1 | output | 1 | Serial data line 1 |
| ready | output | 1 | A buffered frame is waiting |

## Verification
The hardest case to reach from the ports is the cascade. Here a slave sees its clock and frame sync only after they pass through a master's divider and its own resynchroniser, yet it must still launch in the same serial period as the master. The bench places a second instance in slave role, fed by the first instance's `sclk_out` and `fs_out`. It loads both instances in one cycle and samples both sets of data lines on the master's falling edges. The ignored frame sync is reached by draining every pending frame first and then pulsing `fs_in` from the bench-driven slave clock. An overwrite of the buffer is forced by two loads ahead of the sync.

// File: rtl/serout_port.sv
module serout_port #(
  parameter int DIV_W    = 8,
  parameter int WIDE_W   = 24,
  parameter int NARROW_W = 16,
  localparam int CFG_W   = DIV_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              load,
  input  logic [WIDE_W-1:0] a_i,
  input  logic [WIDE_W-1:0] a_q,
  input  logic [WIDE_W-1:0] b_i,
  input  logic [WIDE_W-1:0] b_q,
  input  logic              sclk_in,
  input  logic              fs_in,
  output logic              sclk_out,
  output logic              fs_out,
  output logic              sdo0,
  output logic              sdo1,
  output logic              ready
);

  localparam int FRAME_W = 4 * WIDE_W;
  localparam int PAIR_W  = 2 * WIDE_W;
  localparam int PAD_W   = WIDE_W - NARROW_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {IDLE, ARM, SHIFT} st_t;

  st_t               st;
  logic [CFG_W-1:0]  cfg;
  logic [WIDE_W-1:0] ai_b, aq_b, bi_b, bq_b;
  logic              pend;
  logic [DIV_W-1:0]  dcnt;
  logic              sclk_q, fs_q;
  logic [2:0]        sc_sync;
  logic [1:0]        fs_sync;
  logic [FRAME_W-1:0] sh0, sh1, f0, f1;
  logic [CNT_W-1:0]  bcnt, nbits;

  wire             is_master = cfg[0];
  wire             wide      = cfg[1];
  wire             single    = cfg[2];
  wire [DIV_W-1:0] div       = cfg[CFG_W-1:3];

  wire m_wrap  = is_master && (dcnt == div);
  wire m_rise  = m_wrap && !sclk_q;
  wire m_fall  = m_wrap && sclk_q;
  wire s_rise  = !is_master && sc_sync[1] && !sc_sync[2];
  wire rise    = m_rise || s_rise;
  wire fs_seen = is_master ? fs_q : fs_sync[1];

  assign nbits = wide ? (single ? CNT_W'(4 * WIDE_W)   : CNT_W'(2 * WIDE_W))
                      : (single ? CNT_W'(4 * NARROW_W) : CNT_W'(2 * NARROW_W));

  always_comb begin
    if (wide) begin
      f0 = {ai_b, aq_b, bi_b, bq_b};
      f1 = {bi_b, bq_b, {PAIR_W{1'b0}}};
    end else begin
      f0 = {ai_b[WIDE_W-1:PAD_W], aq_b[WIDE_W-1:PAD_W],
            bi_b[WIDE_W-1:PAD_W], bq_b[WIDE_W-1:PAD_W], {(4*PAD_W){1'b0}}};
      f1 = {bi_b[WIDE_W-1:PAD_W], bq_b[WIDE_W-1:PAD_W],
            {(FRAME_W-2*NARROW_W){1'b0}}};
    end
    if (single) f1 = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg     <= '0;
      sc_sync <= '0;
      fs_sync <= '0;
      dcnt    <= '0;
      sclk_q  <= 1'b0;
      fs_q    <= 1'b0;
    end else begin
      if (cfg_we) cfg <= cfg_wdata;
      sc_sync <= {sc_sync[1:0], sclk_in};
      fs_sync <= {fs_sync[0], fs_in};
      if (!is_master) begin
        dcnt   <= '0;
        sclk_q <= 1'b0;
        fs_q   <= 1'b0;
      end else if (m_wrap) begin
        dcnt   <= '0;
        sclk_q <= !sclk_q;
        if (m_fall) fs_q <= !fs_q && (st == IDLE) && pend;
      end else begin
        dcnt <= dcnt + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      ai_b <= '0;
      aq_b <= '0;
      bi_b <= '0;
      bq_b <= '0;
    end else if (load) begin
      pend <= 1'b1;
      ai_b <= a_i;
      aq_b <= a_q;
      bi_b <= b_i;
      bq_b <= b_q;
    end else if (rise && st == ARM) begin
      pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= IDLE;
      sh0  <= '0;
      sh1  <= '0;
      bcnt <= '0;
    end else if (rise) begin
      case (st)
        IDLE: if (fs_seen && pend) st <= ARM;
        ARM: begin
          sh0  <= f0;
          sh1  <= f1;
          bcnt <= CNT_W'(1);
          st   <= SHIFT;
        end
        SHIFT: begin
          if (bcnt == nbits) begin
            st <= IDLE;
          end else begin
            sh0  <= sh0 << 1;
            sh1  <= sh1 << 1;
            bcnt <= bcnt + CNT_W'(1);
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  assign sclk_out = sclk_q;
  assign fs_out   = fs_q;
  assign ready    = pend;
  assign sdo0     = (st == SHIFT) && sh0[FRAME_W-1];
  assign sdo1     = (st == SHIFT) && sh1[FRAME_W-1];

  AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !is_master |=> (is_master || (!sclk_out && !fs_out))); // R3
  AST_SCLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && !cfg_we && dcnt != div) |=> $stable(sclk_out)); // R3
  AST_FS_NOT_IN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    fs_out |-> st != SHIFT); // R5
  AST_SDO1_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ARM && rise && single) |=> sh1 == '0); // R9
  AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ARM && rise && !load) |=> !ready); // R10
  AST_FRAME_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SHIFT) |-> (bcnt != '0 && bcnt <= nbits)); // R11
  AST_IGNORED_FS: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_master && st == IDLE && rise && !pend) |=> st == IDLE); // R12

endmodule

// File: tb/serout_port_bench.sv
module serout_port_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, cfg_we, c_cfg_we, load, c_load, tb_sclk, tb_fs;
  logic [10:0] cfg_wdata, c_cfg_wdata;
  logic [23:0] ai, aq, bi, bq, cai, caq, cbi, cbq;
  wire sclk_out, fs_out, sdo0, sdo1, ready;
  wire c_sclk_out, c_fs_out, c_sdo0, c_sdo1, c_ready;
  int checks = 0, fails = 0;

  serout_port u_serout_port (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .load(load),
    .a_i(ai), .a_q(aq), .b_i(bi), .b_q(bq), .sclk_in(tb_sclk), .fs_in(tb_fs),
    .sclk_out(sclk_out), .fs_out(fs_out), .sdo0(sdo0), .sdo1(sdo1), .ready(ready));

  serout_port u_casc (
    .clk(clk), .rst_n(rst_n), .cfg_we(c_cfg_we), .cfg_wdata(c_cfg_wdata), .load(c_load),
    .a_i(cai), .a_q(caq), .b_i(cbi), .b_q(cbq), .sclk_in(sclk_out), .fs_in(fs_out),
    .sclk_out(c_sclk_out), .fs_out(c_fs_out), .sdo0(c_sdo0), .sdo1(c_sdo1), .ready(c_ready));

  task automatic chk(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [95:0] efr0(bit w, logic [23:0] a, b, c, d);
    return w ? {a, b, c, d} : {a[23:8], b[23:8], c[23:8], d[23:8], 32'h0};
  endfunction

  function automatic logic [95:0] efr1(bit w, bit s, logic [23:0] c, d);
    if (s) return '0;
    return w ? {c, d, 48'h0} : {c[23:8], d[23:8], 64'h0};
  endfunction

  function automatic logic [95:0] top_bits(logic [95:0] v, int n);
    return v >> (96 - n);
  endfunction

  function automatic logic [95:0] low_bits(logic [95:0] v, int n);
    return v & ((96'h1 << n) - 96'h1);
  endfunction

  task automatic wr_cfg(input bit m, w, s, input logic [7:0] d);
    @(negedge clk); cfg_wdata = {d, s, w, m}; cfg_we = 1'b1;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic wr_ccfg(input bit m, w, s, input logic [7:0] d);
    @(negedge clk); c_cfg_wdata = {d, s, w, m}; c_cfg_we = 1'b1;
    @(negedge clk); c_cfg_we = 1'b0;
  endtask

  task automatic do_load(input logic [23:0] a, b, c, d);
    @(negedge clk); ai = a; aq = b; bi = c; bq = d; load = 1'b1;
    @(negedge clk); load = 1'b0;
  endtask

  task automatic wait_sfall();
    logic p;
    p = sclk_out;
    forever begin
      @(negedge clk);
      if (p && !sclk_out) break;
      p = sclk_out;
    end
  endtask

  task automatic cap_master(input int n, output logic [95:0] g0, g1, c0, c1);
    g0 = '0; g1 = '0; c0 = '0; c1 = '0;
    while (!fs_out) @(negedge clk);
    chk(ready == 1'b1, "R5 ready before sync", 96'(ready), 96'h1);
    wait_sfall();
    chk(fs_out == 1'b0, "R5 sync one period", 96'(fs_out), 96'h0);
    for (int k = 0; k < n; k++) begin
      wait_sfall();
      if (k == 0) chk(ready == 1'b0, "R10 ready low at first bit", 96'(ready), 96'h0);
      g0 = {g0[94:0], sdo0}; g1 = {g1[94:0], sdo1};
      c0 = {c0[94:0], c_sdo0}; c1 = {c1[94:0], c_sdo1};
    end
    wait_sfall();
    chk(!sdo0 && !sdo1 && !fs_out, "R11 idle after frame", 96'({sdo0, sdo1, fs_out}), 96'h0);
  endtask

  task automatic s_period(input bit fsv, output logic b0, b1);
    @(negedge clk); tb_fs = fsv; tb_sclk = 1'b0;
    repeat (6) @(negedge clk);
    tb_sclk = 1'b1;
    repeat (6) @(negedge clk);
    b0 = sdo0; b1 = sdo1;
  endtask

  task automatic t_reset();
    chk({sdo0, sdo1, sclk_out, fs_out, ready} == 5'b0, "R1 outputs after reset",
        96'({sdo0, sdo1, sclk_out, fs_out, ready}), 96'h0);
    repeat (10) @(negedge clk);
    chk(!sclk_out && !fs_out, "R1 slave role after reset", 96'({sclk_out, fs_out}), 96'h0);
  endtask

  task automatic t_clock();
    int per, hi;
    logic p;
    bit fs_seen;
    wr_cfg(1'b1, 1'b0, 1'b0, 8'd2);
    p = sclk_out;
    forever begin @(negedge clk); if (!p && sclk_out) break; p = sclk_out; end
    per = 0; hi = 0; fs_seen = 0; p = sclk_out;
    forever begin
      if (sclk_out) hi++;
      @(negedge clk); per++;
      if (fs_out) fs_seen = 1;
      if (!p && sclk_out) break;
      p = sclk_out;
    end
    chk(per == 6, "R2 R3 sclk period", 96'(per), 96'd6);
    chk(hi == 3, "R3 sclk high time", 96'(hi), 96'd3);
    chk(!fs_seen, "R5 no sync without data", 96'(fs_seen), 96'h0);
  endtask

  task automatic t_master_dual();
    logic [95:0] g0, g1, c0, c1;
    wr_cfg(1'b1, 1'b0, 1'b0, 8'd1);
    do_load(24'hA5C3F1, 24'h3C0F12, 24'h81E7AA, 24'h5A9613);
    chk(ready == 1'b1, "R4 ready after load", 96'(ready), 96'h1);
    cap_master(32, g0, g1, c0, c1);
    chk(low_bits(g0, 32) == top_bits(efr0(0, 24'hA5C3F1, 24'h3C0F12, 24'h81E7AA, 24'h5A9613), 32),
        "R7 R8 sdo0 dual 16", low_bits(g0, 32),
        top_bits(efr0(0, 24'hA5C3F1, 24'h3C0F12, 24'h81E7AA, 24'h5A9613), 32));
    chk(low_bits(g1, 32) == top_bits(efr1(0, 0, 24'h81E7AA, 24'h5A9613), 32),
        "R8 sdo1 dual 16", low_bits(g1, 32), top_bits(efr1(0, 0, 24'h81E7AA, 24'h5A9613), 32));
    chk(c0 == 96'h0 && c1 == 96'h0, "R12 unloaded slave silent", c0 | c1, 96'h0);
  endtask

  task automatic t_master_single();
    logic [95:0] g0, g1, c0, c1;
    wr_cfg(1'b1, 1'b1, 1'b1, 8'd0);
    do_load(24'h123456, 24'hFEDCBA, 24'h800001, 24'h7FFFFE);
    cap_master(96, g0, g1, c0, c1);
    chk(g0 == efr0(1, 24'h123456, 24'hFEDCBA, 24'h800001, 24'h7FFFFE), "R7 R9 sdo0 single 24",
        g0, efr0(1, 24'h123456, 24'hFEDCBA, 24'h800001, 24'h7FFFFE));
    chk(g1 == 96'h0, "R9 sdo1 low in single", g1, 96'h0);
  endtask

  task automatic t_slave();
    logic b0, b1;
    logic [95:0] g0, g1;
    bit any;
    wr_cfg(1'b0, 1'b0, 1'b0, 8'd0);
    repeat (4) @(negedge clk);
    chk(!sclk_out && !fs_out, "R3 slave outputs quiet", 96'({sclk_out, fs_out}), 96'h0);
    any = 0;
    s_period(1'b1, b0, b1);
    for (int k = 0; k < 40; k++) begin
      s_period(1'b0, b0, b1);
      if (b0 || b1 || ready) any = 1;
    end
    chk(!any, "R12 sync without data ignored", 96'(any), 96'h0);
    do_load(24'h111111, 24'h222222, 24'h333333, 24'h444444);
    do_load(24'hC3A501, 24'h96F0FF, 24'h0FF00F, 24'hE1D2C3);
    chk(ready == 1'b1, "R4 ready after reload", 96'(ready), 96'h1);
    s_period(1'b1, b0, b1);
    chk(!b0 && !b1, "R6 no data in sync period", 96'({b0, b1}), 96'h0);
    g0 = '0; g1 = '0;
    for (int k = 0; k < 32; k++) begin
      s_period(1'b0, b0, b1);
      if (k == 0) chk(ready == 1'b0, "R10 slave ready low at first bit", 96'(ready), 96'h0);
      g0 = {g0[94:0], b0}; g1 = {g1[94:0], b1};
    end
    chk(low_bits(g0, 32) == top_bits(efr0(0, 24'hC3A501, 24'h96F0FF, 24'h0FF00F, 24'hE1D2C3), 32),
        "R4 R6 R7 slave sdo0 latest data", low_bits(g0, 32),
        top_bits(efr0(0, 24'hC3A501, 24'h96F0FF, 24'h0FF00F, 24'hE1D2C3), 32));
    chk(low_bits(g1, 32) == top_bits(efr1(0, 0, 24'h0FF00F, 24'hE1D2C3), 32),
        "R8 slave sdo1", low_bits(g1, 32), top_bits(efr1(0, 0, 24'h0FF00F, 24'hE1D2C3), 32));
    s_period(1'b0, b0, b1);
    chk(!b0 && !b1, "R11 slave idle after frame", 96'({b0, b1}), 96'h0);
  endtask

  task automatic t_cascade();
    logic [95:0] g0, g1, c0, c1;
    wr_cfg(1'b1, 1'b1, 1'b0, 8'd3);
    wr_ccfg(1'b0, 1'b1, 1'b0, 8'd0);
    @(negedge clk);
    ai = 24'hABCDEF; aq = 24'h012345; bi = 24'h6789AB; bq = 24'hCDEF01;
    cai = 24'hF0E1D2; caq = 24'hC3B4A5; cbi = 24'h968778; cbq = 24'h695A4B;
    load = 1'b1; c_load = 1'b1;
    @(negedge clk); load = 1'b0; c_load = 1'b0;
    cap_master(48, g0, g1, c0, c1);
    chk(low_bits(g0, 48) == top_bits(efr0(1, 24'hABCDEF, 24'h012345, 24'h6789AB, 24'hCDEF01), 48),
        "R13 master sdo0", low_bits(g0, 48),
        top_bits(efr0(1, 24'hABCDEF, 24'h012345, 24'h6789AB, 24'hCDEF01), 48));
    chk(low_bits(c0, 48) == top_bits(efr0(1, 24'hF0E1D2, 24'hC3B4A5, 24'h968778, 24'h695A4B), 48),
        "R13 slave sdo0 aligned", low_bits(c0, 48),
        top_bits(efr0(1, 24'hF0E1D2, 24'hC3B4A5, 24'h968778, 24'h695A4B), 48));
    chk(low_bits(c1, 48) == top_bits(efr1(1, 0, 24'h968778, 24'h695A4B), 48),
        "R13 slave sdo1 aligned", low_bits(c1, 48), top_bits(efr1(1, 0, 24'h968778, 24'h695A4B), 48));
    chk(c_ready == 1'b0, "R10 slave ready cleared", 96'(c_ready), 96'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; c_cfg_we = 1'b0; load = 1'b0; c_load = 1'b0;
    cfg_wdata = '0; c_cfg_wdata = '0; tb_sclk = 1'b0; tb_fs = 1'b0;
    ai = '0; aq = '0; bi = '0; bq = '0; cai = '0; caq = '0; cbi = '0; cbq = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clock();
    t_master_dual();
    t_master_single();
    t_slave();
    t_cascade();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule